// File: doc/BRIEF.md
# Serial OTP Program and Lock Controller

This block is the command side of a small one-time-programmable store that sits behind a single-lane serial slave port. The port has an active-low select, a serial clock and one data input. The host first issues a write-enable command. It then sends a program command: an opcode, a 24-bit address and one or more data bytes. When select rises, the block starts a self-timed cycle that clears bits in 65 byte cells. Cells 0 to 63 hold data, and cell 64 is a control byte whose bit 0 is a permanent lock.

The serial inputs are sampled in the `clk_i` domain. A rising serial clock is taken as a rising edge of the sampled line, so the serial clock must run well below `clk_i`. The busy and write-enable flags are visible at all times on `status_o`. A combinational read port exposes the cell array, which is modelled as registers that reset to the erased value 0xFF.

Top module: `otp_prog_ctrl`

## Requirements
- R1: A frame is shifted in MSB first while `spi_cs_ni` is low, in this order: an 8-bit opcode, a 24-bit address (most significant byte first), then data bytes. Data byte k is merged into cell (start + k). The start cell is taken from address bits 6..0 only; address bits 23..7 are ignored.
- R2: A program cycle writes each targeted cell with the bitwise AND of its old value and the incoming byte. A cell bit never goes from 0 to 1.
- R3: Opcode 0x06 alone in a frame sets the write-enable flag, and opcode 0x04 alone clears it. A program frame (opcode 0x42) that arrives while the flag is clear changes nothing.
- R4: `status_o[0]` rises on the clock edge that samples select high at the end of an accepted program frame. It stays high for exactly PROG_CYCLES clocks. Cell contents change only on the edge where it falls.
- R5: The write-enable flag is cleared when a program cycle starts, and it reads 0 for the whole cycle.
- R6: A frame whose select falls while a cycle is running is dropped, whatever its opcode. The running cycle and the write-enable flag are left as they were.
- R7: A frame that ends with a partial byte has no effect. So does a program frame with no data byte. In both cases the write-enable flag keeps its value.
- R8: Cell selection advances from cell 64 to cell 0. A byte that lands on a cell already written in the same frame is ANDed with the earlier byte.
- R9: Once bit 0 of cell 64 is 0, later program cycles still run their full length but change none of the 65 cells.
- R10: After reset all cells read 0xFF and `status_o` is 0.
- R11: `status_o` bit 0 is the cycle-in-progress flag and bit 1 is the write-enable flag.
- R12: An address low field of 65..127 selects start cell (field − 65).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; serial inputs are sampled on its rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| spi_cs_ni | input | 1 | Serial select, active low |
| spi_sck_i | input | 1 | Serial clock; data is taken on its rising edge |
| spi_sdi_i | input | 1 | Serial data in |
| status_o | output | 2 | {write-enable flag, cycle-in-progress flag} |
| rd_addr_i | input | $clog2(DATA_BYTES+1) | Cell index for the read port |
| rd_data_o | output | 8 | Cell contents at rd_addr_i; 0xFF when out of range |

## Verification
The bench keeps the default 64 data cells, so the control cell at 64 and the wrap back to cell 0 are reachable with a single 67-byte frame. It sets PROG_CYCLES to 40. That keeps every cycle short enough to time exactly, yet longer than a complete write-enable frame, so a whole frame can be sent and dropped inside one running cycle. A lock is set late in the sequence, and a further program cycle then runs to completion against the frozen array.

// File: rtl/otp_pkg.sv
package otp_pkg;

  typedef logic [7:0] otp_byte_t;

  typedef struct packed {
    logic      stb;
    otp_byte_t data;
  } rx_byte_t;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/otp_spi_rx.sv
module otp_spi_rx
  import otp_pkg::*;
#(
  parameter int unsigned CNT_W = 3,
  parameter int unsigned SAT   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni_i,
  input  logic             sck_i,
  input  logic             sdi_i,
  output logic             cs_fall_o,
  output logic             cs_rise_o,
  output rx_byte_t         byte_o,
  output logic [CNT_W-1:0] idx_o,
  output logic             partial_o
);

  localparam logic [CNT_W-1:0] NB_SAT = CNT_W'(SAT);

  logic             sck_q, cs_q;
  logic [2:0]       bit_q;
  logic [6:0]       sh_q;
  logic [CNT_W-1:0] nb_q;
  logic             sck_rise;

  assign sck_rise  = sck_i & ~sck_q & ~cs_ni_i;
  assign cs_fall_o = ~cs_ni_i & cs_q;
  assign cs_rise_o = cs_ni_i & ~cs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      bit_q <= '0;
      sh_q  <= '0;
      nb_q  <= '0;
    end else begin
      sck_q <= sck_i;
      cs_q  <= cs_ni_i;
      if (cs_fall_o) begin
        bit_q <= '0;
        nb_q  <= '0;
      end else if (sck_rise) begin
        bit_q <= bit_q + 3'd1;
        sh_q  <= {sh_q[5:0], sdi_i};
        // byte index saturates: only "past the header" matters
        if (bit_q == 3'd7 && nb_q != NB_SAT) nb_q <= nb_q + 1'b1;
      end
    end
  end

  assign byte_o.stb  = sck_rise & (bit_q == 3'd7);
  assign byte_o.data = {sh_q, sdi_i};
  assign idx_o       = nb_q;
  assign partial_o   = (bit_q != 3'd0);

endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
  import otp_pkg::*;
#(
  parameter int unsigned CNT_W       = 3,
  parameter int unsigned ADDR_BYTES  = 3,
  parameter int unsigned BYTES       = 65,
  parameter int unsigned OFF_W       = 7,
  parameter int unsigned PROG_CYCLES = 100000,
  parameter logic [7:0]  OPC_PROG    = 8'h42,
  parameter logic [7:0]  OPC_WREN    = 8'h06,
  parameter logic [7:0]  OPC_WRDI    = 8'h04
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_fall_i,
  input  logic             cs_rise_i,
  input  rx_byte_t         byte_i,
  input  logic [CNT_W-1:0] idx_i,
  input  logic             partial_i,
  output logic             wip_o,
  output logic             wel_o,
  output logic             buf_clr_o,
  output logic             buf_wr_o,
  output logic [OFF_W-1:0] buf_off_o,
  output logic             apply_o
);

  localparam int unsigned      TMR_W     = cnt_w(PROG_CYCLES);
  localparam logic [CNT_W-1:0] IDX_ALAST = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] IDX_DATA  = CNT_W'(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] NB_PROG   = CNT_W'(ADDR_BYTES + 2);
  localparam logic [OFF_W-1:0] OFF_LAST  = OFF_W'(BYTES - 1);
  localparam logic [OFF_W-1:0] OFF_SPAN  = OFF_W'(BYTES);
  localparam logic [TMR_W-1:0] TMR_LOAD  = TMR_W'(PROG_CYCLES - 1);

  logic             frame_ok_q, busy_q, wel_q;
  logic [7:0]       opc_q;
  logic [OFF_W-1:0] off_q, raw_off, start_off;
  logic [TMR_W-1:0] tmr_q;
  logic             end_ok, do_wren, do_wrdi, do_prog, prog_frame;

  // low address field folded once into the cell span
  assign raw_off   = byte_i.data[OFF_W-1:0];
  assign start_off = (raw_off >= OFF_SPAN) ? raw_off - OFF_SPAN : raw_off;

  assign prog_frame = frame_ok_q & (opc_q == OPC_PROG);
  assign buf_wr_o   = byte_i.stb & prog_frame & (idx_i >= IDX_DATA);
  assign buf_off_o  = off_q;
  assign buf_clr_o  = cs_fall_i & ~busy_q;

  assign end_ok  = cs_rise_i & frame_ok_q & ~partial_i;
  assign do_wren = end_ok & (idx_i == CNT_W'(1)) & (opc_q == OPC_WREN);
  assign do_wrdi = end_ok & (idx_i == CNT_W'(1)) & (opc_q == OPC_WRDI);
  assign do_prog = end_ok & (opc_q == OPC_PROG) & (idx_i >= NB_PROG) & wel_q;

  assign apply_o = busy_q & (tmr_q == '0);
  assign wip_o   = busy_q;
  assign wel_o   = wel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_ok_q <= 1'b0;
      opc_q      <= '0;
      off_q      <= '0;
    end else begin
      if (cs_fall_i) frame_ok_q <= ~busy_q;
      if (byte_i.stb && idx_i == '0) opc_q <= byte_i.data;
      if (byte_i.stb && idx_i == IDX_ALAST) off_q <= start_off;
      else if (buf_wr_o) off_q <= (off_q == OFF_LAST) ? '0 : off_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
    end else if (do_prog) begin
      wel_q <= 1'b0;
    end else if (do_wren) begin
      wel_q <= 1'b1;
    end else if (do_wrdi) begin
      wel_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      tmr_q  <= '0;
    end else if (do_prog) begin
      busy_q <= 1'b1;
      tmr_q  <= TMR_LOAD;
    end else if (busy_q) begin
      if (tmr_q == '0) busy_q <= 1'b0;
      else             tmr_q  <= tmr_q - 1'b1;
    end
  end

endmodule

// File: rtl/otp_store.sv
module otp_store
  import otp_pkg::*;
#(
  parameter int unsigned BYTES = 65,
  parameter int unsigned OFF_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [OFF_W-1:0]   off_i,
  input  otp_byte_t          wdata_i,
  input  logic               apply_i,
  input  logic [OFF_W-1:0]   rd_addr_i,
  output otp_byte_t          rd_data_o,
  output logic               locked_o,
  output logic [BYTES*8-1:0] mem_o
);

  logic [BYTES-1:0][7:0] mem_w;
  logic [BYTES-1:0][7:0] pend_w;
  logic                  locked;

  assign locked   = ~mem_w[BYTES-1][0];
  assign locked_o = locked;
  assign mem_o    = mem_w;

  for (genvar g = 0; g < BYTES; g++) begin : g_cell
    localparam logic [OFF_W-1:0] MY_OFF = OFF_W'(g);
    otp_byte_t pend_q, cell_q;

    // pending byte: AND-accumulates every byte aimed at this cell in a frame
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          pend_q <= 8'hFF;
      else if (clr_i)                       pend_q <= 8'hFF;
      else if (wr_i && off_i == MY_OFF)     pend_q <= pend_q & wdata_i;
    end

    // cell only clears bits, and only when the array is not locked
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  cell_q <= 8'hFF;
      else if (apply_i && !locked)  cell_q <= cell_q & pend_q;
    end

    assign mem_w[g]  = cell_q;
    assign pend_w[g] = pend_q;
  end

  always_comb begin
    rd_data_o = 8'hFF;
    for (int i = 0; i < BYTES; i++) begin
      if (rd_addr_i == OFF_W'(i)) rd_data_o = mem_w[i];
    end
  end

  logic unused_pend;
  assign unused_pend = ^pend_w;

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_pkg::*;
#(
  parameter int unsigned DATA_BYTES  = 64,
  parameter int unsigned ADDR_BYTES  = 3,
  parameter int unsigned PROG_CYCLES = 100000,
  parameter logic [7:0]  OPC_PROG    = 8'h42,
  parameter logic [7:0]  OPC_WREN    = 8'h06,
  parameter logic [7:0]  OPC_WRDI    = 8'h04
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              spi_cs_ni,
  input  logic                              spi_sck_i,
  input  logic                              spi_sdi_i,
  output logic [1:0]                        status_o,
  input  logic [$clog2(DATA_BYTES+1)-1:0]   rd_addr_i,
  output logic [7:0]                        rd_data_o
);

  localparam int unsigned BYTES = DATA_BYTES + 1;
  localparam int unsigned OFF_W = $clog2(BYTES);
  localparam int unsigned CNT_W = cnt_w(ADDR_BYTES + 3);
  localparam int unsigned SAT   = ADDR_BYTES + 2;

  logic               cs_fall, cs_rise, partial;
  rx_byte_t           rx_byte;
  logic [CNT_W-1:0]   idx;
  logic               wip, wel, buf_clr, buf_wr, apply, locked;
  logic [OFF_W-1:0]   buf_off;
  logic [BYTES*8-1:0] mem_flat;

  otp_spi_rx #(
    .CNT_W (CNT_W),
    .SAT   (SAT)
  ) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_ni_i   (spi_cs_ni),
    .sck_i     (spi_sck_i),
    .sdi_i     (spi_sdi_i),
    .cs_fall_o (cs_fall),
    .cs_rise_o (cs_rise),
    .byte_o    (rx_byte),
    .idx_o     (idx),
    .partial_o (partial)
  );

  otp_cmd_ctrl #(
    .CNT_W       (CNT_W),
    .ADDR_BYTES  (ADDR_BYTES),
    .BYTES       (BYTES),
    .OFF_W       (OFF_W),
    .PROG_CYCLES (PROG_CYCLES),
    .OPC_PROG    (OPC_PROG),
    .OPC_WREN    (OPC_WREN),
    .OPC_WRDI    (OPC_WRDI)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_fall_i (cs_fall),
    .cs_rise_i (cs_rise),
    .byte_i    (rx_byte),
    .idx_i     (idx),
    .partial_i (partial),
    .wip_o     (wip),
    .wel_o     (wel),
    .buf_clr_o (buf_clr),
    .buf_wr_o  (buf_wr),
    .buf_off_o (buf_off),
    .apply_o   (apply)
  );

  otp_store #(
    .BYTES (BYTES),
    .OFF_W (OFF_W)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (buf_clr),
    .wr_i      (buf_wr),
    .off_i     (buf_off),
    .wdata_i   (rx_byte.data),
    .apply_i   (apply),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .locked_o  (locked),
    .mem_o     (mem_flat)
  );

  assign status_o = {wel, wip};

endmodule

// File: rtl/otp_prog_ctrl_chk.sv
module otp_prog_ctrl_chk #(
  parameter int unsigned BYTES = 65
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               wip_i,
  input logic               wel_i,
  input logic               apply_i,
  input logic               cs_rise_i,
  input logic               locked_i,
  input logic [BYTES*8-1:0] mem_i
);

  AST_WEL_LOW_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_i |-> !wel_i); // R5

  AST_BITS_ONLY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mem_i & ~$past(mem_i)) == '0)); // R2

  AST_MEM_STILL_MIDCYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply_i |=> $stable(mem_i)); // R4

  AST_WIP_AFTER_SELECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> $past(cs_rise_i)); // R4

  AST_LOCK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_i |=> $stable(mem_i)); // R9

endmodule

bind otp_prog_ctrl otp_prog_ctrl_chk #(
  .BYTES (DATA_BYTES + 1)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wip_i     (wip),
  .wel_i     (wel),
  .apply_i   (apply),
  .cs_rise_i (cs_rise),
  .locked_i  (locked),
  .mem_i     (mem_flat)
);

// File: tb/tb_otp_prog_ctrl.sv
module tb_otp_prog_ctrl;

  localparam int P  = 40;
  localparam int NB = 65;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       spi_cs_ni = 1'b1;
  logic       spi_sck_i = 1'b0;
  logic       spi_sdi_i = 1'b0;
  logic [1:0] status_o;
  logic [6:0] rd_addr_i = '0;
  logic [7:0] rd_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  always #5 clk_i = ~clk_i;

  otp_prog_ctrl #(.PROG_CYCLES(P)) dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .spi_cs_ni (spi_cs_ni),
    .spi_sck_i (spi_sck_i),
    .spi_sdi_i (spi_sdi_i),
    .status_o  (status_o),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_mem[NB];
  logic [7:0] m_pend[NB];
  bit         m_busy, m_wel, m_ok, m_csp, m_sckp;
  int         m_rem;
  bit         m_bits[$];

  function automatic logic [7:0] m_byte(input int k);
    logic [7:0] b;
    for (int i = 0; i < 8; i++) b[7-i] = m_bits[8*k+i];
    return b;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < NB; i++) m_mem[i] = 8'hFF;
      m_busy = 0; m_wel = 0; m_ok = 0; m_csp = 1; m_sckp = 0; m_rem = 0;
      m_bits.delete();
    end else begin
      bit was_busy;
      was_busy = m_busy;
      if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 0;
          if (m_mem[NB-1][0])
            for (int i = 0; i < NB; i++) m_mem[i] = m_mem[i] & m_pend[i];
        end
      end
      if (m_csp && !spi_cs_ni) begin
        m_ok = !was_busy;
        m_bits.delete();
      end else if (!spi_cs_ni && spi_sck_i && !m_sckp) begin
        m_bits.push_back(spi_sdi_i);
      end else if (!m_csp && spi_cs_ni && m_ok) begin
        int n;
        n = m_bits.size();
        if (n % 8 == 0 && n >= 8) begin
          logic [7:0] opc;
          opc = m_byte(0);
          if (n == 8 && opc == 8'h06) m_wel = 1;
          else if (n == 8 && opc == 8'h04) m_wel = 0;
          else if (opc == 8'h42 && n >= 40 && m_wel) begin
            int off;
            off = m_byte(3) % 128;
            if (off >= NB) off -= NB;
            for (int i = 0; i < NB; i++) m_pend[i] = 8'hFF;
            for (int k = 4; k < n / 8; k++) begin
              m_pend[off] = m_pend[off] & m_byte(k);
              off = (off + 1) % NB;
            end
            m_busy = 1; m_rem = P; m_wel = 0;
          end
        end
      end
      m_csp = spi_cs_ni;
      m_sckp = spi_sck_i;
    end
  end

  // status compared against the model on every clock
  always @(posedge clk_i) begin
    #2;
    if (cmp_on && rst_ni) chk("R11 status vs model", {30'd0, status_o}, {30'd0, m_wel, m_busy});
  end

  // ---------------- stimulus ----------------
  logic [7:0] tx_q[$];

  task automatic bit_out(input logic b);
    @(negedge clk_i); spi_sck_i = 1'b0; spi_sdi_i = b;
    @(negedge clk_i);
    @(negedge clk_i); spi_sck_i = 1'b1;
  endtask

  task automatic send_frame(input int extra_bits);
    @(negedge clk_i); spi_cs_ni = 1'b0;
    @(negedge clk_i);
    foreach (tx_q[j]) for (int i = 7; i >= 0; i--) bit_out(tx_q[j][i]);
    for (int i = 0; i < extra_bits; i++) bit_out(1'b1);
    @(negedge clk_i); spi_sck_i = 1'b0;
    @(negedge clk_i); spi_cs_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic op1(input logic [7:0] opc);
    tx_q = {opc};
    send_frame(0);
  endtask

  task automatic prog_hdr(input logic [23:0] a);
    tx_q = {8'h42, a[23:16], a[15:8], a[7:0]};
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && status_o[0]; i++) @(negedge clk_i);
  endtask

  task automatic peek(input int a, output logic [7:0] d);
    rd_addr_i = 7'(a);
    #1 d = rd_data_o;
  endtask

  task automatic cmp_all(input string tag);
    logic [7:0] d;
    for (int i = 0; i < NB; i++) begin
      peek(i, d);
      chk(tag, {24'd0, d}, {24'd0, m_mem[i]});
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL R4 watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cnt;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    cmp_on = 1'b1;

    // R10 reset state
    chk("R10 status after reset", {30'd0, status_o}, 32'd0);
    peek(0, d);  chk("R10 cell0 erased", {24'd0, d}, 32'hFF);
    peek(64, d); chk("R10 control erased", {24'd0, d}, 32'hFF);

    // R3 program without write enable
    prog_hdr(24'h000000); tx_q.push_back(8'h00); send_frame(0);
    chk("R3 no cycle without WEL", {31'd0, status_o[0]}, 32'd0);
    peek(0, d); chk("R3 cell unchanged", {24'd0, d}, 32'hFF);

    // R3/R11 enable and disable
    op1(8'h06); chk("R11 wel in bit1", {30'd0, status_o}, 32'd2);
    op1(8'h04); chk("R3 wrdi clears", {30'd0, status_o}, 32'd0);

    // R1/R4/R5 basic program, high address bits ignored
    op1(8'h06);
    prog_hdr(24'h123485); tx_q.push_back(8'hA5); tx_q.push_back(8'h3C); send_frame(0);
    chk("R5 wel cleared at start", {30'd0, status_o}, 32'd1);
    peek(5, d); chk("R4 cell still old mid-cycle", {24'd0, d}, 32'hFF);
    cnt = 0;
    while (status_o[0] && cnt < 1000) begin cnt++; @(negedge clk_i); end
    chk("R4 cycle length", cnt, P);
    peek(5, d); chk("R1 first byte at start cell", {24'd0, d}, 32'hA5);
    peek(6, d); chk("R1 second byte next cell", {24'd0, d}, 32'h3C);

    // R2 AND merge
    op1(8'h06);
    prog_hdr(24'h000005); tx_q.push_back(8'hF0); send_frame(0); wait_idle();
    peek(5, d); chk("R2 and merge", {24'd0, d}, 32'hA0);

    // R6 frame during cycle dropped
    op1(8'h06);
    prog_hdr(24'h00000A); tx_q.push_back(8'h11); send_frame(0);
    op1(8'h06);
    chk("R6 wren dropped while busy", {30'd0, status_o}, 32'd1);
    wait_idle();
    chk("R6 wel still clear", {30'd0, status_o}, 32'd0);
    peek(10, d); chk("R6 running cycle intact", {24'd0, d}, 32'h11);

    // R7 partial byte and empty data
    op1(8'h06);
    prog_hdr(24'h000014); tx_q.push_back(8'h00); send_frame(3);
    chk("R7 partial: no cycle, wel kept", {30'd0, status_o}, 32'd2);
    prog_hdr(24'h000014); send_frame(0);
    chk("R7 no data: no cycle, wel kept", {30'd0, status_o}, 32'd2);
    peek(20, d); chk("R7 cell unchanged", {24'd0, d}, 32'hFF);

    // R12 address field above the span
    prog_hdr(24'hABCDD0); tx_q.push_back(8'h5A); send_frame(0); wait_idle();
    peek(15, d); chk("R12 folded start cell", {24'd0, d}, 32'h5A);

    // R8 wrap with 67 bytes from cell 63
    op1(8'h06);
    prog_hdr(24'h00003F);
    for (int k = 0; k < 67; k++)
      tx_q.push_back(k == 0 ? 8'hF7 : k == 1 ? 8'hEF : k == 65 ? 8'h7F : 8'hFF);
    send_frame(0); wait_idle();
    peek(63, d); chk("R8 wrapped byte ANDs", {24'd0, d}, 32'h77);
    peek(64, d); chk("R8 control cell reached", {24'd0, d}, 32'hEF);
    peek(5, d);  chk("R8 other cells kept", {24'd0, d}, 32'hA0);
    cmp_all("R2 array vs model");

    // R9 lock
    op1(8'h06);
    prog_hdr(24'h000040); tx_q.push_back(8'hFE); send_frame(0); wait_idle();
    peek(64, d); chk("R9 lock written", {24'd0, d}, 32'hEE);
    op1(8'h06);
    prog_hdr(24'h000000); tx_q.push_back(8'h00); send_frame(0);
    chk("R9 cycle still runs", {31'd0, status_o[0]}, 32'd1);
    wait_idle();
    peek(0, d); chk("R9 data frozen", {24'd0, d}, 32'hFF);
    op1(8'h06);
    prog_hdr(24'h000040); tx_q.push_back(8'h00); send_frame(0); wait_idle();
    peek(64, d); chk("R9 control frozen", {24'd0, d}, 32'hEE);
    cmp_all("R9 array vs model");

    cmp_on = 1'b0;
    summary();
    $finish;
  end

endmodule